// File: doc/BRIEF.md
# Fractional Baud Strobe Generator

This block produces a one-cycle pacing strobe from a fixed reference clock. The strobe can pace a serial transmitter or a parallel output sequencer. The programmed divisor is an integer part n plus a fraction in eighths (0/8 to 7/8). A period cannot be a fractional number of clock cycles, so each period lasts either n or n+1 cycles. A three-bit phase accumulator picks which periods get the extra cycle, and over time the average period equals the programmed divisor exactly.

The divisor is held in a register. That register reloads only while the block is disabled or in the cycle a strobe is issued, so a change made in the middle of a period never distorts that period. Dropping the enable clears the cycle counter and the phase accumulator. The next run therefore always starts from a known phase.

Top module: `baud_frac_prescaler`

## Requirements
- R1: Each period lasts n cycles, or n+1 cycles when adding the 3-bit fraction code `div_frac` (value in eighths, 0 to 7) to the 3-bit phase accumulator carries out. After each strobe the accumulator keeps the low three bits of that sum.
- R2: With a constant divisor, any 8 consecutive periods total exactly 8n + `div_frac` cycles.
- R3: `div_int` values 2 to 16383 give n equal to the field value. The value 0 gives n = 16384.
- R4: `tick` is high for exactly one cycle per period, never in two consecutive cycles for n ≥ 2, and never while reset is asserted.
- R5: While `en` is low, `tick` stays low and the counter and accumulator are held at zero. After `en` rises, the first period starts at phase 0, so it lasts exactly n cycles.
- R6: A divisor change made during a period leaves that period unchanged. The values present on `div_int`/`div_frac` in the cycle that `tick` is high govern the following period.
- R7: While `en` is low the divisor inputs are captured continuously, so the first period after enabling uses them.
- R8: A fraction code of 0 makes every period exactly n cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the divider idle |
| div_int | input | 14 | Integer part n of the divisor; 0 encodes 16384 |
| div_frac | input | 3 | Fraction of the divisor in eighths |
| tick | output | 1 | One-cycle baud strobe |

## Verification
Two events can fall in the same cycle: the end of a period and a new divisor being presented. The bench provokes this by changing `div_int`/`div_frac` in the very cycle it sees `tick` high. It then judges by period length that the new value governs the next period and not the one just ending. The bench also changes the divisor a few cycles into a period and confirms that the period still runs to its old length. A third case drops `en` partway through a period and changes the divisor while disabled, then checks that no strobe appears and that the restart begins at phase 0 with the new divisor.

// File: rtl/baud_presc_pkg.sv
package baud_presc_pkg;
  localparam int unsigned DEF_INT_W  = 14;
  localparam int unsigned DEF_FRAC_W = 3;
endpackage

// File: rtl/baud_div_hold.sv
module baud_div_hold #(
  parameter int unsigned INT_W  = 14,
  parameter int unsigned FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [INT_W-1:0]  int_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [INT_W-1:0]  int_q,
  output logic [FRAC_W-1:0] frac_q
);
  logic [INT_W-1:0]  int_d;
  logic [FRAC_W-1:0] frac_d;

  always_comb begin
    int_d  = int_q;
    frac_d = frac_q;
    if (load) begin
      int_d  = int_in;
      frac_d = frac_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q  <= '0;
      frac_q <= '0;
    end else begin
      int_q  <= int_d;
      frac_q <= frac_d;
    end
  end
endmodule

// File: rtl/baud_phase_accum.sv
module baud_phase_accum #(
  parameter int unsigned FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic [FRAC_W-1:0] acc_q,
  output logic              carry
);
  logic [FRAC_W:0]   sum;
  logic [FRAC_W-1:0] acc_d;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, frac};
    carry = sum[FRAC_W];
    if (!run) begin
      acc_d = '0;
    end else if (step) begin
      acc_d = sum[FRAC_W-1:0];
    end else begin
      acc_d = acc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/baud_period_counter.sv
module baud_period_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] last,
  output logic [CNT_W-1:0] cnt_q,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    tick = run && (cnt_q == last);
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/baud_frac_prescaler.sv
module baud_frac_prescaler
  import baud_presc_pkg::*;
#(
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              tick
);
  localparam int unsigned CNT_W = INT_W + 1;

  logic [INT_W-1:0]  n_q;
  logic [FRAC_W-1:0] f_q;
  logic [FRAC_W-1:0] acc_q;
  logic              carry;
  logic              load;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  n_eff;
  logic [CNT_W-1:0]  last;

  assign load = !en || tick;

  baud_div_hold #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .int_in  (div_int),
    .frac_in (div_frac),
    .int_q   (n_q),
    .frac_q  (f_q)
  );

  baud_phase_accum #(.FRAC_W(FRAC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en),
    .step  (tick),
    .frac  (f_q),
    .acc_q (acc_q),
    .carry (carry)
  );

  always_comb begin
    if (n_q == '0) begin
      n_eff = CNT_W'(1) << INT_W;
    end else begin
      n_eff = {1'b0, n_q};
    end
    last = n_eff - CNT_W'(1) + CNT_W'(carry);
  end

  baud_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en),
    .last  (last),
    .cnt_q (cnt_q),
    .tick  (tick)
  );
endmodule

// File: rtl/baud_frac_prescaler_checks.sv
module baud_frac_prescaler_checks #(
  parameter int unsigned INT_W  = 14,
  parameter int unsigned FRAC_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              tick,
  input logic [INT_W-1:0]  div_int,
  input logic [INT_W-1:0]  n_hold,
  input logic [FRAC_W-1:0] f_hold,
  input logic [FRAC_W-1:0] acc,
  input logic [INT_W:0]    cnt
);
  localparam int unsigned CHK_W = INT_W + 2;

  logic [CHK_W-1:0] gap;
  logic [CHK_W-1:0] neff;

  always_comb begin
    if (n_hold == '0) begin
      neff = CHK_W'(1) << INT_W;
    end else begin
      neff = {2'b00, n_hold};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
    end else if (!en || tick) begin
      gap <= '0;
    end else begin
      gap <= gap + CHK_W'(1);
    end
  end

  assert_quiet_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !tick);

  assert_clear_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc == '0 && cnt == '0));

  assert_hold_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> ($stable(n_hold) && $stable(f_hold)));

  assert_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ((gap + CHK_W'(1) == neff) || (gap + CHK_W'(1) == neff + CHK_W'(1))));

  assert_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_int != INT_W'(1)) |=> !tick);
endmodule

bind baud_frac_prescaler baud_frac_prescaler_checks #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .tick    (tick),
  .div_int (div_int),
  .n_hold  (n_q),
  .f_hold  (f_q),
  .acc     (acc_q),
  .cnt     (cnt_q)
);

// File: tb/tb_baud_frac_prescaler.sv
module tb_baud_frac_prescaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [13:0] div_int = '0;
  logic [2:0]  div_frac = '0;
  logic        tick;

  int vectors = 0;
  int errors = 0;
  int cyc = 0;
  int model_acc = 0;
  bit done = 1'b0;

  baud_frac_prescaler dut (
    .clk(clk), .rst_n(rst_n), .en(en),
    .div_int(div_int), .div_frac(div_frac), .tick(tick)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++;
      vectors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 16384 : n;
  endfunction

  function automatic int exp_len(input int n, input int f, input int acc);
    return eff(n) + (((acc + f) >= 8) ? 1 : 0);
  endfunction

  task automatic measure(inout int len);
    do begin
      @(negedge clk);
      #1;
      len++;
    end while (!tick && len < 20000);
  endtask

  task automatic start(input int n, input int f);
    @(posedge clk); #1;
    en = 1'b0; div_int = 14'(n); div_frac = 3'(f);
    @(posedge clk); #1;
    en = 1'b1;
    model_acc = 0;
  endtask

  task automatic run(input int n, input int f, input int periods, input string req);
    int sum = 0;
    start(n, f);
    for (int k = 0; k < periods; k++) begin
      int len = 0;
      int e;
      measure(len);
      e = exp_len(n, f, model_acc);
      model_acc = (model_acc + f) % 8;
      check(len == e, req, len, e);
      sum += len;
      if (k == 7) check(sum == 8 * eff(n) + f, "R2 eight-period total", sum, 8 * eff(n) + f);
    end
  endtask

  initial begin
    int len;
    int e;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 en = 1'b1;
    @(negedge clk); #1;
    check(tick == 1'b0, "R4 no strobe in reset", int'(tick), 0);
    @(posedge clk); #1 rst_n = 1'b1; en = 1'b0;

    // R3: field 0 means 16384
    run(0, 5, 2, "R3 zero encodes 16384");
    // R1 minimum integer, largest fraction
    run(2, 7, 9, "R1 n=2 f=7 period");
    // R8 integer-only
    run(9, 0, 8, "R8 fraction zero exact");
    run(16383, 0, 1, "R3 top field value");
    run(13, 4, 8, "R1 half step");

    // R6: change mid-period keeps current period
    start(10, 0);
    len = 0; measure(len);
    check(len == 10, "R6 first period", len, 10);
    len = 0;
    repeat (3) begin @(negedge clk); #1; len++; end
    div_int = 14'd5; div_frac = 3'd3;
    measure(len);
    check(len == 10, "R6 mid-period change ignored", len, 10);
    model_acc = 0;
    for (int k = 0; k < 3; k++) begin
      len = 0; measure(len);
      e = exp_len(5, 3, model_acc);
      model_acc = (model_acc + 3) % 8;
      check(len == e, "R6 new divisor after strobe", len, e);
    end
    // R6: change in the strobe cycle itself governs next period
    div_int = 14'd7; div_frac = 3'd2;
    len = 0; measure(len);
    e = exp_len(7, 2, model_acc);
    model_acc = (model_acc + 2) % 8;
    check(len == e, "R6 change coincident with strobe", len, e);

    // R5/R7: disable mid-period, change divisor, re-enable
    @(posedge clk); #1;
    @(posedge clk); #1;
    en = 1'b0;
    div_int = 14'd6; div_frac = 3'd4;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); #1;
      check(tick == 1'b0, "R5 no strobe while disabled", int'(tick), 0);
    end
    @(posedge clk); #1;
    en = 1'b1;
    model_acc = 0;
    for (int k = 0; k < 4; k++) begin
      len = 0; measure(len);
      e = exp_len(6, 4, model_acc);
      model_acc = (model_acc + 4) % 8;
      check(len == e, "R7 R5 restart at phase 0 with captured divisor", len, e);
    end

    // Constrained random divisors
    for (int c = 0; c < 20; c++) begin
      int n = 2 + int'($urandom % 40);
      int f = int'($urandom % 8);
      run(n, f, 10, "R1 random divisor");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule